// File: doc/BRIEF.md
# Shared-Timebase Multi-Channel PWM Timer

This timer drives several edge-aligned PWM outputs from one timebase. The timebase is a power-of-two prescaler, one up-counter and one modulus register, and every channel uses it. Each channel compares the shared count against its own active compare value. A per-channel polarity bit picks whether the output starts each period high or low. Because the period belongs to the unit, changing the modulus changes the period of every channel, and with it every channel's effective duty.

Software drives the unit through a single-cycle register write port and reads it back through a combinational read port. A new compare value is not applied straight away. The first compare write in a PWM cycle is stored in a buffer. The buffer moves into the active compare register when the counter wraps, or when the counter is force-cleared by a write to the counter register. Any further compare write to the same channel before that load is silently discarded. Writing the counter gives software a way to end the cycle early and re-arm all channels.

Top module: `pwm_timer_unit`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the modulus reads 0xFFFF, every active compare reads 0, every mode bit is 0 (high-true), and every output is low.
- R2: Register map. Address 0 is control: bits [2:0] hold the prescale exponent PS, bits [4:3] hold the clock mode, and bit 7 is the wrap flag. Address 1 is the counter. Address 2 is the modulus. Channel n uses address 4+2n for its compare value and 5+2n for its mode, where bit 0 = 1 selects low-true output. With clock mode 01 the counter advances exactly once every 2^PS clocks. With any other clock mode the counter holds its value.
- R3: While counting, the counter goes from the modulus M back to 0, so one period lasts M+1 ticks. The wrap sets the flag. Writing control with bit 7 = 1 clears the flag.
- R4: In high-true mode, with compare value C and C <= M+1, a channel's output is high for exactly C ticks of each period, namely while the counter is below C.
- R5: In low-true mode, the output is the inverse of the high-true output, so it is low for min(C, M+1) ticks of each period.
- R6: When the compare value is larger than M, a high-true output stays high for the whole period, and a low-true output stays low for the whole period.
- R7: Only the first compare write to a channel in a PWM cycle is accepted. Later writes to that channel in the same cycle have no effect. The accepted value becomes active at the next wrap, and the compare readback shows the active value.
- R8: Writing the counter register sets the counter to 0. This also loads any pending compare value into the active register and re-arms every channel to accept a new write, even while the counter is stopped.
- R9: A write to control updates PS only if the clock-mode readback is 00 at the moment of the write. The clock-mode readback shows the written clock mode one cycle after the write, and counting follows that readback.
- R10: A modulus change applies to all channels together. With compare values held, every channel's high-time per period stays the same while the period length changes, and duty clamps where the compare value exceeds the new modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (4) | Write address |
| wdata_i | input | CW (16) | Write data |
| rd_addr_i | input | AW (4) | Read address |
| rdata_o | output | CW (16) | Read data (combinational) |
| pwm_o | output | NCH (6) | PWM outputs, one bit per channel |

## Verification
Embedded assertions check several rules on every cycle. The counter either steps by one or returns to zero, and it is zero after a counter write. The prescaler field changes only while the clock-mode readback is zero. The flag rises only on a wrap and falls only on a clear write. A repeated compare write leaves the buffer untouched, and the active compare changes only on a load event. A high-true channel whose compare exceeds the modulus is high. Duty per period, the exact tick rate for each prescale setting, the one-cycle clock-mode acknowledge, and the sequence of accepted versus dropped writes across wraps and counter resets are only visible in the bench scenarios. The bench sweeps compare values across and beyond the modulus in both polarities and counts high samples over a full period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_CNT     = 1;
  localparam int unsigned ADDR_MOD     = 2;
  localparam int unsigned ADDR_CH_BASE = 4;
  localparam int unsigned CTRL_PS_LSB  = 0;
  localparam int unsigned CTRL_CM_LSB  = 3;
  localparam int unsigned CTRL_FLAG    = 7;
  localparam logic [1:0]  CMOD_RUN     = 2'b01;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctrl_wr_i,
  input  logic [PSW-1:0] ps_wdata_i,
  input  logic [1:0]     cmod_wdata_i,
  input  logic           flag_clr_i,
  input  logic           wrap_i,
  output logic [PSW-1:0] ps_o,
  output logic [1:0]     cmod_o,
  output logic           flag_o
);
  logic [PSW-1:0] ps_q;
  logic [1:0]     cmod_q, cmod_rd_q;
  logic           flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q      <= '0;
      cmod_q    <= '0;
      cmod_rd_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      cmod_rd_q <= cmod_q;
      if (ctrl_wr_i) begin
        cmod_q <= cmod_wdata_i;
        if (cmod_rd_q == 2'b00) ps_q <= ps_wdata_i;
      end
      if (wrap_i) flag_q <= 1'b1;
      else if (ctrl_wr_i && flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign ps_o   = ps_q;
  assign cmod_o = cmod_rd_q;
  assign flag_o = flag_q;

  p_ps_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ps_q) |-> $past(cmod_rd_q) == 2'b00);
  p_flag_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(wrap_i));
  p_flag_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(ctrl_wr_i && flag_clr_i));
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           clr_i,
  input  logic [PSW-1:0] ps_i,
  output logic           tick_o
);
  localparam int unsigned DW = (1 << PSW) - 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;

  always_comb mask = DW'((1 << ps_i) - 1);

  assign tick_o = en_i && (&(div_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  input  logic          mod_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] mod_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, mod_q;

  // >= so a lowered modulus still ends the cycle
  assign wrap_o = tick_i && !cnt_wr_i && (cnt_q >= mod_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= '1;
    end else begin
      if (mod_wr_i) mod_q <= wdata_i;
      if (cnt_wr_i)    cnt_q <= '0;
      else if (wrap_o) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign mod_o = mod_q;

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + CW'(1)));
  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmp_wr_i,
  input  logic          mode_wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cmp_o,
  output logic          low_true_o,
  output logic          pwm_o
);
  logic [CW-1:0] buf_q, act_q;
  logic          armed_n_q;
  logic          low_true_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      act_q      <= '0;
      armed_n_q  <= 1'b0;
      low_true_q <= 1'b0;
    end else begin
      if (mode_wr_i) low_true_q <= wdata_i[0];
      // a write landing on a load belongs to the new cycle
      if (load_i) begin
        if (armed_n_q) act_q <= buf_q;
        armed_n_q <= cmp_wr_i;
      end else if (cmp_wr_i) begin
        armed_n_q <= 1'b1;
      end
      if (cmp_wr_i && (load_i || !armed_n_q)) buf_q <= wdata_i;
    end
  end

  assign cmp_o      = act_q;
  assign low_true_o = low_true_q;
  assign pwm_o      = low_true_q ^ (cnt_i < act_q);

  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i && armed_n_q && !load_i) |=> $stable(buf_q));
  p_act_on_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(load_i));
  p_full_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!low_true_q && act_q > mod_i && cnt_i <= mod_i) |-> pwm_o);
endmodule

// File: rtl/pwm_timer_unit.sv
module pwm_timer_unit
  import pwm_timer_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3,
  parameter int unsigned AW  = $clog2(ADDR_CH_BASE + 2 * NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [CW-1:0]  wdata_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [CW-1:0]  rdata_o,
  output logic [NCH-1:0] pwm_o
);
  logic           ctrl_wr, cnt_wr, mod_wr;
  logic [PSW-1:0] ps;
  logic [1:0]     cmod;
  logic           flag, tick, wrap, load;
  logic [CW-1:0]  cnt, mod;
  logic [CW-1:0]  cmp_act [NCH];
  logic [NCH-1:0] low_true;

  assign ctrl_wr = wr_en_i && (wr_addr_i == AW'(ADDR_CTRL));
  assign cnt_wr  = wr_en_i && (wr_addr_i == AW'(ADDR_CNT));
  assign mod_wr  = wr_en_i && (wr_addr_i == AW'(ADDR_MOD));
  assign load    = wrap || cnt_wr;

  pwm_ctrl #(.PSW(PSW)) u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_wr_i    (ctrl_wr),
    .ps_wdata_i   (wdata_i[CTRL_PS_LSB +: PSW]),
    .cmod_wdata_i (wdata_i[CTRL_CM_LSB +: 2]),
    .flag_clr_i   (wdata_i[CTRL_FLAG]),
    .wrap_i       (wrap),
    .ps_o         (ps),
    .cmod_o       (cmod),
    .flag_o       (flag)
  );

  pwm_prescale #(.PSW(PSW)) u_pre (
    .clk_i, .rst_ni,
    .en_i   (cmod == CMOD_RUN),
    .clr_i  (cnt_wr),
    .ps_i   (ps),
    .tick_o (tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .cnt_wr_i (cnt_wr),
    .mod_wr_i (mod_wr),
    .wdata_i,
    .cnt_o    (cnt),
    .mod_o    (mod),
    .wrap_o   (wrap)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] A_CMP  = AW'(ADDR_CH_BASE + 2 * n);
    localparam logic [AW-1:0] A_MODE = AW'(ADDR_CH_BASE + 2 * n + 1);
    pwm_channel #(.CW(CW)) u_ch (
      .clk_i, .rst_ni,
      .cmp_wr_i   (wr_en_i && wr_addr_i == A_CMP),
      .mode_wr_i  (wr_en_i && wr_addr_i == A_MODE),
      .wdata_i,
      .load_i     (load),
      .cnt_i      (cnt),
      .mod_i      (mod),
      .cmp_o      (cmp_act[n]),
      .low_true_o (low_true[n]),
      .pwm_o      (pwm_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_addr_i == AW'(ADDR_CTRL)) begin
      rdata_o[CTRL_PS_LSB +: PSW] = ps;
      rdata_o[CTRL_CM_LSB +: 2]   = cmod;
      rdata_o[CTRL_FLAG]          = flag;
    end else if (rd_addr_i == AW'(ADDR_CNT)) begin
      rdata_o = cnt;
    end else if (rd_addr_i == AW'(ADDR_MOD)) begin
      rdata_o = mod;
    end
    for (int n = 0; n < NCH; n++) begin
      if (rd_addr_i == AW'(ADDR_CH_BASE + 2 * n))     rdata_o = cmp_act[n];
      if (rd_addr_i == AW'(ADDR_CH_BASE + 2 * n + 1)) rdata_o = CW'(low_true[n]);
    end
  end

  p_hold_when_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmod != CMOD_RUN && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/pwm_timer_unit_tb.sv
module pwm_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rdata;
  logic [5:0]  pwm;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_timer_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wdata_i(wdata), .rd_addr_i(rd_addr), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic measure(input int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h0 += int'(pwm[0]);
      h1 += int'(pwm[1]);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, v0, v1, h0, h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 cnt", v, 0);
    rd(2, v); chk("R1 mod", v, 16'hFFFF);
    rd(4, v); chk("R1 cmp0", v, 0);
    rd(15, v); chk("R1 mode5", v, 0);
    chk("R1 pwm", int'(pwm), 0);

    // R9 prescaler lock and delayed clock-mode acknowledge
    wr(0, 16'h0008);
    @(negedge clk);
    rd(0, v); chk("R9 run ack", v, 16'h0008);
    wr(0, 16'h000B);
    rd(0, v); chk("R9 ps locked", v, 16'h0008);
    wr(0, 16'h0003);
    rd(0, v); chk("R9 cmod old", v, 16'h0008);
    @(negedge clk);
    rd(0, v); chk("R9 cmod zero", v, 16'h0000);
    wr(0, 16'h000B);
    rd(0, v); chk("R9 ps taken", v, 16'h0003);
    @(negedge clk);
    rd(0, v); chk("R9 cmod one", v, 16'h000B);

    // R2 tick rate per prescale, and hold when stopped
    for (int p = 0; p < 4; p++) begin
      wr(0, 0);
      @(negedge clk);
      wr(0, p);
      wr(0, 16'h0008 | p);
      wr(1, 0);
      rd(1, v0);
      repeat (5 * (1 << p)) @(negedge clk);
      rd(1, v1);
      chk($sformatf("R2 ps%0d", p), v1 - v0, 5);
    end
    wr(0, 0);
    @(negedge clk);
    rd(1, v0);
    repeat (10) @(negedge clk);
    rd(1, v1);
    chk("R2 stopped", v1, v0);

    // R3 wrap at modulus and flag
    wr(0, 16'h0008);
    wr(2, 5);
    wr(1, 0);
    wr(0, 16'h0088);
    rd(1, v); chk("R3 cnt start", v, 2);
    rd(0, v); chk("R3 flag cleared", v >> 7, 0);
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      rd(1, v); chk("R3 cnt seq", v, (2 + i) % 6);
      if (i == 4) begin
        rd(0, v); chk("R3 flag set", v >> 7, 1);
      end
    end
    wr(0, 16'h0088);
    rd(0, v); chk("R3 flag clr", v >> 7, 0);

    // R4 R5 R6 sweep, ch0 high-true, ch1 low-true, M=7
    wr(2, 7);
    wr(7, 1);
    wr(5, 0);
    wr(1, 0);
    for (int c = 0; c <= 9; c++) begin
      wr(4, c);
      wr(6, c);
      wr(1, 0);
      measure(8, h0, h1);
      chk($sformatf("R4 R6 high cv%0d", c), h0, min2(c, 8));
      chk($sformatf("R5 R6 low cv%0d", c), h1, 8 - min2(c, 8));
    end

    // R10 shared modulus
    wr(7, 0);
    wr(1, 0);
    wr(4, 2);
    wr(6, 6);
    wr(1, 0);
    measure(8, h0, h1);
    chk("R10 ch0 M7", h0, 2);
    chk("R10 ch1 M7", h1, 6);
    wr(2, 3);
    wr(1, 0);
    measure(4, h0, h1);
    chk("R10 ch0 M3", h0, 2);
    chk("R10 ch1 M3", h1, 4);

    // R7 one accepted write per cycle
    wr(2, 7);
    wr(1, 0);
    wr(4, 3);
    wr(4, 6);
    rd(4, v); chk("R7 not yet active", v, 2);
    repeat (8) @(negedge clk);
    rd(4, v); chk("R7 first write active", v, 3);
    measure(8, h0, h1);
    chk("R7 duty first write", h0, 3);
    wr(4, 5);
    repeat (16) @(negedge clk);
    rd(4, v); chk("R7 next cycle write", v, 5);
    measure(8, h0, h1);
    chk("R7 duty next write", h0, 5);

    // R8 counter write loads and re-arms while stopped
    wr(0, 0);
    @(negedge clk);
    wr(4, 9);
    wr(4, 1);
    rd(4, v); chk("R8 pending", v, 5);
    wr(1, 0);
    rd(4, v); chk("R8 loaded", v, 9);
    rd(1, v); chk("R8 cnt zero", v, 0);
    wr(4, 4);
    wr(1, 0);
    rd(4, v); chk("R8 rearmed", v, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule